// File: doc/BRIEF.md
# Aperture page remapping table

This block remaps bus addresses that fall inside a fixed window (the aperture) onto physical memory, one 4 KiB page at a time. Each page of the aperture owns one table entry held on chip. An entry carries a valid flag and a physical page frame. An address that falls outside the aperture is passed through untouched.

Software never addresses the table directly. It goes through a small window of three 32-bit registers on a simple register bus. A control register holds a global translation enable. A page-select register latches the aperture address of the page to work on. An entry register reads or writes the entry that the latched address selects.

A separate lookup port accepts a request address. One cycle later it answers with either the translated address or a fault. The aperture base, the page count and the lookup latency are parameters.

Top module: `aprt_remap`

## Requirements
- R1: After reset, translation is disabled, every entry is invalid and the page-select register holds zero.
- R2: Register words are decoded from reg_addr[3:2]: 0 is the control register, 1 is the page-select register and 2 is the entry register. reg_addr[1:0] is ignored. Word 3 reads as zero, and writes to it have no effect. The control register keeps only wdata bit 0 (1 = translate) and reads back as {31'b0, enable}. The page-select register reads back the full 32-bit value last written.
- R3: A write to the entry register updates the entry of page index (page-select − APT_BASE) >> 12. Bit 31 of the written word is the valid flag and bits 30:12 are the frame. All other bits are dropped.
- R4: A read of the entry register returns {valid, frame, 12'b0} for the entry picked by the current page-select value. All register read data appears on reg_rdata in the cycle after reg_rd.
- R5: While the page-select value lies outside the aperture [APT_BASE, APT_BASE + NUM_PAGES·4096), entry-register writes change no entry and entry-register reads return zero.
- R6: A lookup inside the aperture, with translation enabled and the entry valid, returns lk_pa = {1'b0, frame, lk_addr[11:0]} with lk_fault = 0. Results appear with lk_ack one cycle after lk_req (LK_LAT = 1).
- R7: A lookup inside the aperture while translation is disabled, or while the entry is invalid, returns lk_fault = 1 and lk_pa = 0.
- R8: A lookup outside the aperture returns lk_pa = lk_addr with lk_fault = 0, whatever the enable and the table hold.
- R9: Writing the word zero to an entry clears its mapping, so later lookups of that page fault.
- R10: An entry or control write is seen by a lookup presented in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup bus address |
| lk_ack | output | 1 | Lookup result valid |
| lk_pa | output | 32 | Translated or passed-through address |
| lk_fault | output | 1 | Lookup faulted |

## Verification
The bench builds the block with an aperture base of 0x5800_0000, 64 pages and the registered lookup. The aperture then ends at 0x5804_0000. With this build the first and last pages are reached, as are the addresses one below the base and exactly at the end. The full table is also small enough to be scanned page by page after the directed cases and again after the random traffic. Random traffic mixes page-select writes that land both inside and outside the aperture, entry writes (including zero) and enable toggles. Lookups are aimed near both edges, so that ignored writes and same-cycle-after visibility are both exercised.

// File: rtl/aprt_pkg.sv
package aprt_pkg;
   localparam int unsigned DW       = 32;
   localparam int unsigned PG_SHIFT = 12;
   localparam int unsigned VLD_BIT  = DW - 1;
   localparam int unsigned FRAME_W  = DW - 1 - PG_SHIFT;

   // register window word select (reg_addr[3:2])
   typedef enum logic [1:0] {
      WIN_CTRL  = 2'd0,
      WIN_PSEL  = 2'd1,
      WIN_ENTRY = 2'd2,
      WIN_SPARE = 2'd3
   } win_sel_e;

   typedef struct packed {
      logic               vld;
      logic [FRAME_W-1:0] frame;
   } pte_t;

   function automatic pte_t pte_from_word(input logic [DW-1:0] w);
      pte_t p;
      p.vld   = w[VLD_BIT];
      p.frame = w[DW-2:PG_SHIFT];
      return p;
   endfunction

   function automatic logic [DW-1:0] pte_to_word(input pte_t p);
      return {p.vld, p.frame, {PG_SHIFT{1'b0}}};
   endfunction
endpackage

// File: rtl/aprt_range.sv
module aprt_range
   import aprt_pkg::*;
#(
   parameter logic [31:0] APT_BASE  = 32'h5800_0000,
   parameter int unsigned NUM_PAGES = 64
) (
   input  logic [DW-1:0]                addr,
   output logic                         hit,
   output logic [$clog2(NUM_PAGES)-1:0] idx
);
   localparam int unsigned IDX_W = $clog2(NUM_PAGES);
   localparam int unsigned PN_W  = DW - PG_SHIFT;
   localparam logic [PN_W-1:0] PN_LIMIT = PN_W'(NUM_PAGES);

   logic [DW-1:0]       off;
   logic [PN_W-1:0]     pn;
   logic [PG_SHIFT-1:0] unused_lo;

   always_comb begin
      off = addr - APT_BASE;
      pn  = off[DW-1:PG_SHIFT];
   end

   assign unused_lo = off[PG_SHIFT-1:0];
   // R5 R8: half-open aperture test, no end-address overflow
   assign hit = (addr >= APT_BASE) && (pn < PN_LIMIT);
   assign idx = pn[IDX_W-1:0];
endmodule

// File: rtl/aprt_table.sv
module aprt_table
   import aprt_pkg::*;
#(
   parameter int unsigned NUM_PAGES = 64
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [$clog2(NUM_PAGES)-1:0] widx,
   input  pte_t                         wpte,
   input  logic [$clog2(NUM_PAGES)-1:0] ridx,
   output pte_t                         rpte,
   input  logic [$clog2(NUM_PAGES)-1:0] lidx,
   output pte_t                         lpte
);
   pte_t ent_q [NUM_PAGES];

   // R1: every entry invalid out of reset; R3 R9: single write port
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_PAGES; i++) ent_q[i] <= '0;
      end else if (we) begin
         ent_q[widx] <= wpte;
      end
   end

   assign rpte = ent_q[ridx];
   assign lpte = ent_q[lidx];
endmodule

// File: rtl/aprt_regwin.sv
module aprt_regwin
   import aprt_pkg::*;
#(
   parameter logic [31:0] APT_BASE  = 32'h5800_0000,
   parameter int unsigned NUM_PAGES = 64
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         reg_wr,
   input  logic                         reg_rd,
   input  logic [3:0]                   reg_addr,
   input  logic [DW-1:0]                reg_wdata,
   output logic [DW-1:0]                reg_rdata,
   output logic                         cfg_en,
   output logic                         tbl_we,
   output logic [$clog2(NUM_PAGES)-1:0] tbl_idx,
   output pte_t                         tbl_wpte,
   input  pte_t                         tbl_rpte
);
   win_sel_e      sel;
   logic [DW-1:0] psel_q;
   logic          en_q;
   logic          psel_hit;
   logic [DW-1:0] rd_mux;
   logic [DW-1:0] rdata_q;
   logic [1:0]    unused_byte;

   assign sel         = win_sel_e'(reg_addr[3:2]);
   assign unused_byte = reg_addr[1:0];

   aprt_range #(.APT_BASE(APT_BASE), .NUM_PAGES(NUM_PAGES)) psel_rng_i (
      .addr (psel_q),
      .hit  (psel_hit),
      .idx  (tbl_idx)
   );

   // R2 R1: control and page-select registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         psel_q <= '0;
      end else if (reg_wr) begin
         if (sel == WIN_CTRL) en_q   <= reg_wdata[0];
         if (sel == WIN_PSEL) psel_q <= reg_wdata;
      end
   end

   // R3 R5: entry writes only land inside the aperture
   assign tbl_we   = reg_wr && (sel == WIN_ENTRY) && psel_hit;
   assign tbl_wpte = pte_from_word(reg_wdata);

   // R4 R5 R2: read mux
   always_comb begin
      unique case (sel)
         WIN_CTRL:  rd_mux = {{(DW-1){1'b0}}, en_q};
         WIN_PSEL:  rd_mux = psel_q;
         WIN_ENTRY: rd_mux = psel_hit ? pte_to_word(tbl_rpte) : '0;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (reg_rd) rdata_q <= rd_mux;
   end

   assign reg_rdata = rdata_q;
   assign cfg_en    = en_q;
endmodule

// File: rtl/aprt_lookup.sv
module aprt_lookup
   import aprt_pkg::*;
#(
   parameter logic [31:0] APT_BASE  = 32'h5800_0000,
   parameter int unsigned NUM_PAGES = 64,
   parameter int unsigned LK_LAT    = 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         lk_req,
   input  logic [DW-1:0]                lk_addr,
   input  logic                         cfg_en,
   output logic [$clog2(NUM_PAGES)-1:0] lidx,
   input  pte_t                         lpte,
   output logic                         lk_ack,
   output logic [DW-1:0]                lk_pa,
   output logic                         lk_fault
);
   logic          in_apt;
   logic [DW-1:0] pa_d;
   logic          fault_d;

   aprt_range #(.APT_BASE(APT_BASE), .NUM_PAGES(NUM_PAGES)) lk_rng_i (
      .addr (lk_addr),
      .hit  (in_apt),
      .idx  (lidx)
   );

   // R6 R7 R8: translate, fault or pass through
   always_comb begin
      if (!in_apt) begin
         pa_d    = lk_addr;
         fault_d = 1'b0;
      end else if (cfg_en && lpte.vld) begin
         pa_d    = {1'b0, lpte.frame, lk_addr[PG_SHIFT-1:0]};
         fault_d = 1'b0;
      end else begin
         pa_d    = '0;
         fault_d = 1'b1;
      end
   end

   generate
      if (LK_LAT == 1) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lk_ack   <= 1'b0;
               lk_pa    <= '0;
               lk_fault <= 1'b0;
            end else begin
               lk_ack   <= lk_req;
               lk_pa    <= lk_req ? pa_d : '0;
               lk_fault <= lk_req && fault_d;
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign lk_ack     = lk_req;
         assign lk_pa      = lk_req ? pa_d : '0;
         assign lk_fault   = lk_req && fault_d;
      end
   endgenerate
endmodule

// File: rtl/aprt_remap.sv
module aprt_remap
   import aprt_pkg::*;
#(
   parameter logic [31:0] APT_BASE  = 32'h5800_0000,
   parameter int unsigned NUM_PAGES = 64,
   parameter int unsigned LK_LAT    = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [3:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        lk_req,
   input  logic [31:0] lk_addr,
   output logic        lk_ack,
   output logic [31:0] lk_pa,
   output logic        lk_fault
);
   localparam int unsigned IDX_W = $clog2(NUM_PAGES);
   localparam longint unsigned APT_END = longint'(APT_BASE) + longint'(NUM_PAGES) * 4096;

   initial begin
      if (NUM_PAGES < 2) $error("NUM_PAGES must be at least 2");
      if (APT_BASE[PG_SHIFT-1:0] != '0) $error("APT_BASE must be page aligned");
      if (APT_END > 64'h1_0000_0000) $error("aperture runs past the address space");
      if (LK_LAT > 1) $error("LK_LAT must be 0 or 1");
   end

   logic             cfg_en;
   logic             tbl_we;
   logic [IDX_W-1:0] tbl_idx;
   logic [IDX_W-1:0] lidx;
   pte_t             tbl_wpte;
   pte_t             tbl_rpte;
   pte_t             lpte;

   aprt_regwin #(.APT_BASE(APT_BASE), .NUM_PAGES(NUM_PAGES)) win_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .cfg_en    (cfg_en),
      .tbl_we    (tbl_we),
      .tbl_idx   (tbl_idx),
      .tbl_wpte  (tbl_wpte),
      .tbl_rpte  (tbl_rpte)
   );

   aprt_table #(.NUM_PAGES(NUM_PAGES)) tbl_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (tbl_we),
      .widx  (tbl_idx),
      .wpte  (tbl_wpte),
      .ridx  (tbl_idx),
      .rpte  (tbl_rpte),
      .lidx  (lidx),
      .lpte  (lpte)
   );

   aprt_lookup #(.APT_BASE(APT_BASE), .NUM_PAGES(NUM_PAGES), .LK_LAT(LK_LAT)) lk_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_req   (lk_req),
      .lk_addr  (lk_addr),
      .cfg_en   (cfg_en),
      .lidx     (lidx),
      .lpte     (lpte),
      .lk_ack   (lk_ack),
      .lk_pa    (lk_pa),
      .lk_fault (lk_fault)
   );
endmodule

// File: rtl/aprt_remap_chk.sv
module aprt_remap_chk #(
   parameter logic [31:0] APT_BASE  = 32'h5800_0000,
   parameter int unsigned NUM_PAGES = 64,
   parameter int unsigned LK_LAT    = 1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_wr,
   input logic        reg_rd,
   input logic [1:0]  win,
   input logic        cfg_bit,
   input logic [31:0] reg_rdata,
   input logic        cfg_en,
   input logic        lk_req,
   input logic [31:0] lk_addr,
   input logic        lk_ack,
   input logic [31:0] lk_pa,
   input logic        lk_fault
);
   function automatic logic in_apt(input logic [31:0] a);
      logic [31:0] off;
      off = a - APT_BASE;
      return (a >= APT_BASE) && ((off >> 12) < 32'(NUM_PAGES));
   endfunction

   AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n) reg_wr && win == 2'd0 |=> cfg_en == $past(cfg_bit)); // R2
   AST_CTRL_READ: assert property (@(posedge clk) disable iff (!rst_n) reg_rd && win == 2'd0 |=> reg_rdata == {31'b0, $past(cfg_en)}); // R4
   AST_SPARE_READ: assert property (@(posedge clk) disable iff (!rst_n) reg_rd && win == 2'd3 |=> reg_rdata == 32'h0); // R2
   AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n) lk_fault |-> lk_ack && lk_pa == 32'h0); // R7

   generate
      if (LK_LAT == 1) begin : g_lat1
         AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) lk_req |=> lk_ack); // R6
         AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n) !lk_req |=> !lk_ack); // R6
         AST_OUTSIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n) lk_req && !in_apt(lk_addr) |=> !lk_fault && lk_pa == $past(lk_addr)); // R8
         AST_DISABLED_FAULT: assert property (@(posedge clk) disable iff (!rst_n) lk_req && in_apt(lk_addr) && !cfg_en |=> lk_fault); // R7
         AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n) lk_req && in_apt(lk_addr) |=> lk_fault || (lk_pa[11:0] == $past(lk_addr[11:0]) && !lk_pa[31])); // R6
      end else begin : g_lat0
         AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) lk_req |-> lk_ack); // R6
         AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n) !lk_req |-> !lk_ack); // R6
         AST_OUTSIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n) lk_req && !in_apt(lk_addr) |-> !lk_fault && lk_pa == lk_addr); // R8
         AST_DISABLED_FAULT: assert property (@(posedge clk) disable iff (!rst_n) lk_req && in_apt(lk_addr) && !cfg_en |-> lk_fault); // R7
         AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n) lk_req && in_apt(lk_addr) |-> lk_fault || (lk_pa[11:0] == lk_addr[11:0] && !lk_pa[31])); // R6
      end
   endgenerate
endmodule

bind aprt_remap aprt_remap_chk #(.APT_BASE(APT_BASE), .NUM_PAGES(NUM_PAGES), .LK_LAT(LK_LAT)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .win       (reg_addr[3:2]),
   .cfg_bit   (reg_wdata[0]),
   .reg_rdata (reg_rdata),
   .cfg_en    (cfg_en),
   .lk_req    (lk_req),
   .lk_addr   (lk_addr),
   .lk_ack    (lk_ack),
   .lk_pa     (lk_pa),
   .lk_fault  (lk_fault)
);

// File: tb/aprt_remap_tb_top.sv
module aprt_remap_tb_top;
   localparam logic [31:0] BASE = 32'h5800_0000;
   localparam int unsigned NP   = 64;
   localparam logic [31:0] ENDA = BASE + NP * 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        lk_req = 1'b0;
   logic [31:0] lk_addr = '0;
   logic        lk_ack;
   logic [31:0] lk_pa;
   logic        lk_fault;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   logic [31:0] m_tab [NP];
   bit          m_en;
   logic [31:0] m_psel;

   always #4 clk = ~clk;

   aprt_remap #(.APT_BASE(BASE), .NUM_PAGES(NP), .LK_LAT(1)) dut_i (
      .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
      .lk_req, .lk_addr, .lk_ack, .lk_pa, .lk_fault
   );

   function automatic bit b_in(input logic [31:0] a);
      return (a >= BASE) && (a < ENDA);
   endfunction

   function automatic int b_idx(input logic [31:0] a);
      return int'((a - BASE) >> 12);
   endfunction

   function automatic logic [31:0] exp_entry_rd();
      if (!b_in(m_psel)) return 32'h0;
      return m_tab[b_idx(m_psel)];
   endfunction

   function automatic logic [32:0] exp_lk(input logic [31:0] a);
      logic [31:0] e;
      if (!b_in(a)) return {1'b0, a};
      e = m_tab[b_idx(a)];
      if (m_en && e[31]) return {1'b0, 1'b0, e[30:12], a[11:0]};
      return {1'b1, 32'h0};
   endfunction

   function automatic logic [31:0] rand_addr();
      case ($urandom % 4)
         0:       return BASE - 32'd1 - ($urandom % 8192);
         1:       return ENDA + ($urandom % 8192);
         default: return BASE + ($urandom % (NP * 4096));
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
      case (a[3:2])
         2'd0: m_en = d[0];
         2'd1: m_psel = d;
         2'd2: if (b_in(m_psel)) m_tab[b_idx(m_psel)] = d & 32'hFFFF_F000;
         default: ;
      endcase
   endtask

   task automatic rd_reg(input logic [3:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(posedge clk); #1;
      reg_rd = 1'b0;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic look(input logic [31:0] a, input string tag);
      logic [32:0] e;
      e = exp_lk(a);
      @(negedge clk);
      lk_req = 1'b1; lk_addr = a;
      @(posedge clk); #1;
      lk_req = 1'b0;
      chk({tag, " ack"}, {31'b0, lk_ack}, 32'h1);
      chk({tag, " pa"}, lk_pa, e[31:0]);
      chk({tag, " fault"}, {31'b0, lk_fault}, {31'b0, e[32]});
   endtask

   task automatic scan(input string tag);
      for (int p = 0; p < NP; p++) look(BASE + p * 4096 + (p * 37 % 4096), tag);
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_up();
   end

   initial begin
      for (int i = 0; i < NP; i++) m_tab[i] = 32'h0;
      m_en = 1'b0; m_psel = 32'h0;
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd_reg(4'h0, 32'h0, "R1 ctrl after reset");
      rd_reg(4'h4, 32'h0, "R1 page-select after reset");
      look(BASE, "R1 first page faults");
      look(ENDA - 1, "R1 last page faults");
      // R5 page-select zero lies outside
      rd_reg(4'h8, 32'h0, "R5 entry read outside");
      wr_reg(4'h4, BASE);
      rd_reg(4'h8, 32'h0, "R1 entry zero after reset");

      // R3 extra bits dropped, R4 read-back format
      wr_reg(4'h8, 32'hFFFF_FFFF);
      rd_reg(4'h8, 32'hFFFF_F000, "R3 entry bits dropped");
      rd_reg(4'hB, 32'hFFFF_F000, "R2 byte offset ignored");
      rd_reg(4'hC, 32'h0, "R2 spare word reads zero");
      wr_reg(4'hC, 32'hFFFF_FFFF);
      rd_reg(4'h0, 32'h0, "R2 spare write no effect");
      look(BASE + 32'h123, "R7 disabled faults");

      // R10 enable then immediate lookup, R6
      wr_reg(4'h0, 32'h0000_0003);
      look(BASE + 32'h123, "R10 R6 enable visible");
      rd_reg(4'h0, 32'h1, "R2 ctrl keeps bit0");
      wr_reg(4'h4, ENDA - 4096);
      rd_reg(4'h4, ENDA - 4096, "R2 page-select readback");
      wr_reg(4'h8, 32'h8001_2000);
      look(ENDA - 1, "R10 R6 entry visible next cycle");

      // R8 outside passes
      look(BASE - 1, "R8 below base");
      look(ENDA, "R8 at end");
      look(32'h0000_0000, "R8 zero");

      // R9 clear
      wr_reg(4'h8, 32'h0);
      look(ENDA - 4096, "R9 cleared faults");
      rd_reg(4'h8, 32'h0, "R9 cleared reads zero");

      // R7 frame without valid flag
      wr_reg(4'h4, BASE + 5 * 4096);
      wr_reg(4'h8, 32'h0001_5000);
      look(BASE + 5 * 4096 + 32'h10, "R7 invalid entry faults");

      // R5 page-select outside: write ignored
      wr_reg(4'h4, ENDA);
      wr_reg(4'h8, 32'h8000_1000);
      rd_reg(4'h8, 32'h0, "R5 read outside zero");
      wr_reg(4'h4, BASE - 4096);
      wr_reg(4'h8, 32'h8000_2000);
      scan("R5 table untouched");

      // R7 disable again, R8 unaffected
      wr_reg(4'h0, 32'h0);
      look(BASE, "R7 disabled again");
      look(BASE - 1, "R8 outside while disabled");

      // random traffic
      for (int it = 0; it < 600; it++) begin
         case ($urandom % 8)
            0, 1: wr_reg(4'h4, ($urandom % 8 == 0) ? rand_addr()
                                                    : BASE + ($urandom % NP) * 4096 + ($urandom % 4096));
            2:    wr_reg(4'h8, ($urandom % 4 == 0) ? 32'h0 : $urandom);
            3:    wr_reg(4'h0, {31'b0, ($urandom % 4 != 0)});
            4:    rd_reg(4'h8, exp_entry_rd(), "R4 random entry read");
            5:    rd_reg(4'h0, {31'b0, m_en}, "R2 random ctrl read");
            default: look(rand_addr(), "R6 random lookup");
         endcase
      end

      wr_reg(4'h0, 32'h1);
      scan("R6 final scan");
      finish_up();
   end
endmodule